// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the digital front end of a 512-byte serial EEPROM that sits on a two-wire (I2C-style) bus. It oversamples the bus clock and data lines with the system clock and detects START and STOP conditions. It answers its device address when the strap pins match, and keeps a word address counter. That counter serves random reads, current-address reads, sequential reads and page writes. The storage array is a synchronous RAM model inside the block.

Page writes are collected in a 16-byte buffer. The buffer index wraps inside the current page. When the master sends STOP, a self-timed write cycle of `WR_CYCLES` system clocks begins. During that cycle the buffered bytes are copied into the array, and the device does not acknowledge its address. A write-protect input keeps the upper 256 bytes unchanged while it is high. Bytes aimed there are still acknowledged on the bus, but they are then dropped.

The data line is open-drain. The block only ever pulls it low, through `sda_pull_o`, and the board pull-up supplies the high level.

Top module: `eeprom_2w_slave`

## Requirements
- R1: After reset the block releases SDA (`sda_pull_o` = 0), is not in a write cycle and acknowledges its first matching address.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The first byte after START is the device byte, sent MSB first, as bit7..bit4 = 1010, bit3 = A2, bit2 = A1, bit1 = block select, bit0 = read(1)/write(0). The block acknowledges it (pulls SDA low in the ninth clock) only when bits 7..4 equal 1010 and bits 3..2 equal `strap_i[1:0]`. Otherwise it stays released.
- R3: In a write, the byte after the device byte sets the low 8 bits of the word address. The device byte's block-select bit sets address bit 8.
- R4: Data bytes in a write go into a 16-byte page buffer at the counter's low 4 bits. Those bits wrap from 15 to 0 while bits 8..4 stay fixed, so a seventeenth byte replaces the first. All buffered bytes are committed together after STOP.
- R5: A STOP that ends a write with at least one data byte starts a write cycle lasting `WR_CYCLES` system clocks. During it the device byte is not acknowledged. Afterwards it is acknowledged again.
- R6: While `wp_i` is high, data bytes for addresses 256..511 are acknowledged but are not committed. Addresses 0..255 remain writable.
- R7: A random read (a write of device byte and word address, then a repeated START and a read device byte) returns the byte stored at that address.
- R8: In a read, the byte at the counter is shifted out MSB first and the counter then advances by one over all 9 bits, rolling from 511 to 0. A master ACK (SDA low in the ninth clock) continues with the next byte. A master NACK ends the read with SDA released.
- R9: A read device byte without a preceding word address returns the byte at the current counter.
- R10: A START that arrives before STOP discards the bytes buffered so far, and no write cycle follows.
- R11: The block changes the state of SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_i | input | 2 | Address straps: bit1 = A2, bit0 = A1 |
| wp_i | input | 1 | Write protect for addresses 256..511 when high |

## Verification
On every cycle the assertions check four things. SDA changes only after an SCL fall or a bus condition. SDA stays released in idle and throughout a write cycle, and that cycle lasts exactly `WR_CYCLES` clocks and is never restarted while it runs. While bytes are written into the page buffer, the counter keeps its page bits and steps its low bits with wrap. The bench scenarios are needed to show what the array ends up holding and what the bus returns: the address match against straps and device type, page wrap and overwrite, the block-select bit and 511-to-0 rollover, dropped protected bytes, a write aborted by a repeated START, and the NACK during the write cycle.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WR,
    ST_ACK,
    ST_RD,
    ST_RACK
  } ee2w_state_e;

  localparam logic [3:0] EE2W_DEV_TYPE = 4'b1010;
  localparam int         EE2W_BYTE_W   = 8;

endpackage

// File: rtl/ee2w_sync.sv
module ee2w_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_s,
  output logic wp_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int LANES   = 3;
  localparam int CHAIN_W = STAGES * LANES;

  logic [LANES-1:0]   raw;
  logic [LANES-1:0]   synced;
  logic [CHAIN_W-1:0] chain_q;
  logic               scl_q;
  logic               sda_q;
  logic               scl_s;

  assign raw = {wp_i, sda_i, scl_i};

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[CHAIN_W-LANES-1:0], raw};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= raw;
      end
    end
  endgenerate

  assign synced = chain_q[CHAIN_W-1 -: LANES];
  assign scl_s  = synced[0];
  assign sda_s  = synced[1];
  assign wp_s   = synced[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/ee2w_ctrl.sv
module ee2w_ctrl
  import ee2w_pkg::*;
#(
  parameter int         ADDR_W   = 9,
  parameter int         PAGE_W   = 4,
  parameter logic [3:0] DEV_TYPE = EE2W_DEV_TYPE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic              wp_s,
  input  logic [1:0]        strap,
  input  logic              busy,
  input  logic [7:0]        rd_data,
  output logic              sda_pull,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_din,
  output logic              buf_keep,
  output logic              buf_clear,
  output logic              commit_go,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              idle
);

  localparam int         OFF_W     = ADDR_W - 1;
  localparam logic [3:0] BITS_DONE = 4'd8;
  localparam logic [3:0] LAST_OUT  = 4'd7;

  ee2w_state_e       state_q, state_d;
  ee2w_state_e       ret_q, ret_d;
  logic [7:0]        shreg_q, shreg_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              mack_q, mack_d;
  logic              pend_q, pend_d;
  logic              hit;

  assign hit = (shreg_q[7:4] == DEV_TYPE) && (shreg_q[3:2] == strap) && !busy;

  always_comb begin
    state_d   = state_q;
    ret_d     = ret_q;
    shreg_d   = shreg_q;
    cnt_d     = cnt_q;
    ptr_d     = ptr_q;
    mack_d    = mack_q;
    pend_d    = pend_q;
    buf_we    = 1'b0;
    buf_clear = 1'b0;
    commit_go = 1'b0;
    if (stop_evt) begin
      state_d   = ST_IDLE;
      commit_go = pend_q;
      pend_d    = 1'b0;
    end else if (start_evt) begin
      state_d   = ST_DEV;
      cnt_d     = '0;
      pend_d    = 1'b0;
      buf_clear = 1'b1;
    end else begin
      case (state_q)
        ST_DEV, ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            shreg_d = {shreg_q[6:0], sda_s};
            cnt_d   = cnt_q + 4'd1;
          end else if (scl_fall && (cnt_q == BITS_DONE)) begin
            cnt_d = '0;
            if (state_q == ST_DEV) begin
              if (hit) begin
                ptr_d[ADDR_W-1] = shreg_q[1];
                state_d         = ST_ACK;
                ret_d           = shreg_q[0] ? ST_RD : ST_ADDR;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_ADDR) begin
              ptr_d[OFF_W-1:0] = shreg_q[OFF_W-1:0];
              state_d          = ST_ACK;
              ret_d            = ST_WR;
            end else begin
              buf_we             = 1'b1;
              pend_d             = 1'b1;
              ptr_d[PAGE_W-1:0]  = ptr_q[PAGE_W-1:0] + PAGE_W'(1);
              state_d            = ST_ACK;
              ret_d              = ST_WR;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state_d = ret_q;
            cnt_d   = '0;
            if (ret_q == ST_RD) begin
              shreg_d = rd_data;
              ptr_d   = ptr_q + ADDR_W'(1);
            end
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            shreg_d = {shreg_q[6:0], 1'b1};
            cnt_d   = cnt_q + 4'd1;
            if (cnt_q == LAST_OUT) state_d = ST_RACK;
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              shreg_d = rd_data;
              ptr_d   = ptr_q + ADDR_W'(1);
              cnt_d   = '0;
              state_d = ST_RD;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      shreg_q <= '1;
      cnt_q   <= '0;
      ptr_q   <= '0;
      mack_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      ptr_q   <= ptr_d;
      mack_q  <= mack_d;
      pend_q  <= pend_d;
    end
  end

  assign sda_pull = (state_q == ST_ACK) || ((state_q == ST_RD) && !shreg_q[7]);
  assign buf_addr = ptr_q;
  assign buf_din  = shreg_q;
  assign buf_keep = ~(wp_s & ptr_q[ADDR_W-1]);
  assign cur_addr = ptr_q;
  assign idle     = (state_q == ST_IDLE);

endmodule

// File: rtl/ee2w_store.sv
module ee2w_store #(
  parameter int DEPTH     = 512,
  parameter int PAGE      = 16,
  parameter int WR_CYCLES = 750000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_we,
  input  logic [$clog2(DEPTH)-1:0] buf_addr,
  input  logic [7:0]               buf_din,
  input  logic                     buf_keep,
  input  logic                     buf_clear,
  input  logic                     commit_go,
  output logic                     busy,
  output logic                     mem_we,
  output logic [$clog2(DEPTH)-1:0] mem_addr,
  output logic [7:0]               mem_din
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PAGE_W = $clog2(PAGE);
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam int TMR_W  = $clog2(WR_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WR_CYCLES - 1);
  localparam logic [TMR_W-1:0] TMR_PAGE = TMR_W'(PAGE);

  logic [7:0]        slot_q [PAGE];
  logic [PAGE-1:0]   valid_q, valid_d;
  logic [BASE_W-1:0] base_q;
  logic              busy_q, busy_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [PAGE_W-1:0] idx;
  logic [PAGE_W-1:0] cidx;
  logic              fill;
  logic              done;

  assign idx  = buf_addr[PAGE_W-1:0];
  assign cidx = tmr_q[PAGE_W-1:0];
  assign fill = buf_we && buf_keep && !busy_q;
  assign done = busy_q && (tmr_q == TMR_LAST);

  generate
    for (genvar g = 0; g < PAGE; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (fill && (idx == PAGE_W'(g))) slot_q[g] <= buf_din;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      base_q <= '0;
    else if (fill)   base_q <= buf_addr[ADDR_W-1:PAGE_W];
  end

  always_comb begin
    valid_d = valid_q;
    busy_d  = busy_q;
    tmr_d   = tmr_q;
    if (busy_q) begin
      tmr_d = tmr_q + TMR_W'(1);
      if (done) begin
        busy_d  = 1'b0;
        valid_d = '0;
      end
    end else begin
      if (buf_clear) valid_d = '0;
      if (fill)      valid_d[idx] = 1'b1;
      if (commit_go) begin
        busy_d = 1'b1;
        tmr_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      busy_q  <= 1'b0;
      tmr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      busy_q  <= busy_d;
      tmr_q   <= tmr_d;
    end
  end

  assign busy     = busy_q;
  assign mem_we   = busy_q && (tmr_q < TMR_PAGE) && valid_q[cidx];
  assign mem_addr = {base_q, cidx};
  assign mem_din  = slot_q[cidx];

endmodule

// File: rtl/ee2w_ram.sv
module ee2w_ram #(
  parameter int DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [7:0]               wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [7:0]               rdata
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave #(
  parameter int DEPTH       = 512,
  parameter int PAGE        = 16,
  parameter int WR_CYCLES   = 750000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [1:0] strap_i,
  input  logic       wp_i
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PAGE_W = $clog2(PAGE);

  logic              rst_meta_n;
  logic              rst_sync_n;
  logic              sda_s, wp_s;
  logic              scl_rise, scl_fall, start_evt, stop_evt;
  logic              busy;
  logic              sda_pull;
  logic              buf_we, buf_keep, buf_clear, commit_go, idle;
  logic [ADDR_W-1:0] buf_addr, cur_addr, mem_addr;
  logic [7:0]        buf_din, mem_din, rd_data;
  logic              mem_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  ee2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .wp_i      (wp_i),
    .sda_s     (sda_s),
    .wp_s      (wp_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  ee2w_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_s     (sda_s),
    .wp_s      (wp_s),
    .strap     (strap_i),
    .busy      (busy),
    .rd_data   (rd_data),
    .sda_pull  (sda_pull),
    .buf_we    (buf_we),
    .buf_addr  (buf_addr),
    .buf_din   (buf_din),
    .buf_keep  (buf_keep),
    .buf_clear (buf_clear),
    .commit_go (commit_go),
    .cur_addr  (cur_addr),
    .idle      (idle)
  );

  ee2w_store #(.DEPTH(DEPTH), .PAGE(PAGE), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .buf_we    (buf_we),
    .buf_addr  (buf_addr),
    .buf_din   (buf_din),
    .buf_keep  (buf_keep),
    .buf_clear (buf_clear),
    .commit_go (commit_go),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_din   (mem_din)
  );

  ee2w_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_din),
    .raddr (cur_addr),
    .rdata (rd_data)
  );

  assign sda_pull_o = sda_pull;

endmodule

// File: rtl/ee2w_chk.sv
module ee2w_chk #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 750000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_pull,
  input logic              scl_fall,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              busy,
  input logic              commit_go,
  input logic              buf_we,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              idle
);

  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_pull);

  a_r11_sda_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));

  a_r5_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> !busy);

  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == WR_CYCLES));

  a_r5_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_len < WR_CYCLES));

  a_r4_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $past(buf_we) |->
      ((cur_addr[ADDR_W-1:PAGE_W] == $past(cur_addr[ADDR_W-1:PAGE_W])) &&
       (cur_addr[PAGE_W-1:0] == PAGE_W'($past(cur_addr[PAGE_W-1:0]) + 1'b1))));

endmodule

bind eeprom_2w_slave ee2w_chk #(
  .ADDR_W    (ADDR_W),
  .PAGE_W    (PAGE_W),
  .WR_CYCLES (WR_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sda_pull  (sda_pull),
  .scl_fall  (scl_fall),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .busy      (busy),
  .commit_go (commit_go),
  .buf_we    (buf_we),
  .cur_addr  (cur_addr),
  .idle      (idle)
);

// File: tb/eeprom_2w_slave_tb.sv
module eeprom_2w_slave_tb;

  localparam int WRC = 1500;
  localparam int QT  = 10;
  localparam int HT  = 20;

  logic       clk;
  logic       rst_n;
  logic       scl_m;
  logic       sda_m;
  logic       wp;
  logic [1:0] strap;
  logic       sda_pull;
  wire        sda_line = sda_m & ~sda_pull;

  int checks = 0;
  int errors = 0;
  int viol   = 0;
  bit done   = 0;

  int    exp_q[$];
  int    obs_q[$];
  string tag_q[$];

  eeprom_2w_slave #(.WR_CYCLES(WRC)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .strap_i    (strap),
    .wp_i       (wp)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // scoreboard monitor
  always @(posedge clk) begin
    if (exp_q.size() > 0 && obs_q.size() > 0) begin
      int    e;
      int    o;
      string t;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (e != o) begin
        errors++;
        $display("FAIL %s actual %0h expected %0h", t, o, e);
      end
    end
  end

  // R11 watcher: SDA held while SCL high
  logic last_pull = 1'b0;
  logic last_scl  = 1'b1;
  always @(negedge clk) begin
    if (rst_n && scl_m && last_scl && (sda_pull != last_pull)) viol++;
    last_pull = sda_pull;
    last_scl  = scl_m;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_item(input string tag, input int v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(QT);
    scl_m = 1'b1; tick(HT);
    sda_m = 1'b0; tick(HT);
    scl_m = 1'b0; tick(QT);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(QT);
    scl_m = 1'b1; tick(HT);
    sda_m = 1'b1; tick(HT);
  endtask

  task automatic put(input logic [7:0] b, input string tag, input int exp_ack);
    int acked;
    expect_item(tag, exp_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(QT);
      scl_m = 1'b1; tick(HT);
      scl_m = 1'b0; tick(QT);
    end
    sda_m = 1'b1; tick(QT);
    scl_m = 1'b1; tick(HT / 2);
    acked = (sda_line == 1'b0) ? 1 : 0;
    tick(HT / 2);
    scl_m = 1'b0; tick(QT);
    obs_q.push_back(acked);
  endtask

  task automatic get(input bit mack, input string tag, input int exp);
    logic [7:0] v;
    expect_item(tag, exp);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(QT);
      scl_m = 1'b1; tick(HT / 2);
      v[i] = sda_line;
      tick(HT / 2);
      scl_m = 1'b0;
    end
    tick(QT / 2);
    sda_m = mack ? 1'b0 : 1'b1; tick(QT);
    scl_m = 1'b1; tick(HT);
    scl_m = 1'b0;
    sda_m = 1'b1; tick(QT);
    obs_q.push_back(int'(v));
  endtask

  // random read of one byte; device bytes use strap 2'b10
  task automatic read_at(input logic [8:0] a, input string tag, input int exp);
    bus_start();
    put(a[8] ? 8'hAA : 8'hA8, tag, 1);
    put(a[7:0], tag, 1);
    bus_start();
    put(a[8] ? 8'hAB : 8'hA9, tag, 1);
    get(1'b0, tag, exp);
    bus_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    scl_m = 1'b1;
    sda_m = 1'b1;
    wp    = 1'b0;
    strap = 2'b10;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(10);

    check_eq("R1 reset releases sda", int'(sda_pull), 0);

    // R2: straps and device type must both match
    bus_start(); put(8'hA4, "R2 strap mismatch nack", 0); bus_stop();
    bus_start(); put(8'hB8, "R2 type mismatch nack", 0); bus_stop();

    // R1/R3/R4: page write at 0x0E wrapping into 0x00
    bus_start();
    put(8'hA8, "R1 first match acked", 1);
    put(8'h0E, "R3 word address acked", 1);
    put(8'hA0, "R4 data acked", 1);
    put(8'hA1, "R4 data acked", 1);
    put(8'hA2, "R4 data acked", 1);
    bus_stop();

    // R5: no ack during write cycle, ack afterwards
    bus_start(); put(8'hA8, "R5 busy nack", 0); bus_stop();
    tick(WRC);
    bus_start(); put(8'hA8, "R5 ready ack", 1); bus_stop();

    // R7 random read then R9 current-address read
    bus_start();
    put(8'hA8, "R7 dev", 1);
    put(8'h0E, "R7 addr", 1);
    bus_start();
    put(8'hA9, "R7 read dev", 1);
    get(1'b0, "R7 random read", 8'hA0);
    bus_stop();
    bus_start();
    put(8'hA9, "R9 dev", 1);
    get(1'b0, "R9 current address read", 8'hA1);
    bus_stop();
    read_at(9'h000, "R4 wrap to page start", 8'hA2);

    // R4 overwrite: 17 bytes at 0x20
    bus_start();
    put(8'hA8, "R4 dev", 1);
    put(8'h20, "R4 addr", 1);
    for (int i = 0; i < 17; i++) put(8'(8'h50 + i), "R4 page byte acked", 1);
    bus_stop();
    tick(WRC);
    bus_start();
    put(8'hA8, "R8 dev", 1);
    put(8'h20, "R8 addr", 1);
    bus_start();
    put(8'hA9, "R8 read dev", 1);
    for (int i = 0; i < 16; i++)
      get(i < 15, (i == 0) ? "R4 seventeenth overwrote first" : "R8 sequential read",
          (i == 0) ? 8'h60 : 8'h50 + i);
    check_eq("R8 released after nack", int'(sda_pull), 0);
    bus_stop();

    // R3 block select and R8 rollover 511 -> 0
    bus_start();
    put(8'hAA, "R3 upper dev", 1);
    put(8'hFF, "R3 upper addr", 1);
    put(8'hC3, "R3 upper data", 1);
    bus_stop();
    tick(WRC);
    bus_start();
    put(8'hAA, "R8 dev", 1);
    put(8'hFF, "R8 addr", 1);
    bus_start();
    put(8'hAB, "R8 read dev", 1);
    get(1'b1, "R3 block select reaches 0x1FF", 8'hC3);
    get(1'b0, "R8 rollover to 0x000", 8'hA2);
    bus_stop();

    // R6 write protect
    wp = 1'b1;
    tick(10);
    bus_start();
    put(8'hAA, "R6 dev", 1);
    put(8'hFF, "R6 addr", 1);
    put(8'h99, "R6 protected byte acked", 1);
    bus_stop();
    tick(WRC);
    bus_start();
    put(8'hA8, "R6 dev", 1);
    put(8'h05, "R6 addr", 1);
    put(8'h42, "R6 lower byte acked", 1);
    bus_stop();
    tick(WRC);
    read_at(9'h1FF, "R6 upper unchanged", 8'hC3);
    read_at(9'h005, "R6 lower half written", 8'h42);
    wp = 1'b0;
    tick(10);

    // R10 repeated START aborts buffered write
    bus_start();
    put(8'hA8, "R10 dev", 1);
    put(8'h05, "R10 addr", 1);
    put(8'h11, "R10 data", 1);
    bus_start();
    put(8'hA8, "R10 no write cycle", 1);
    put(8'h05, "R10 addr", 1);
    bus_start();
    put(8'hA9, "R10 read dev", 1);
    get(1'b0, "R10 data kept", 8'h42);
    bus_stop();
    bus_start(); put(8'hA8, "R10 still idle after stop", 1); bus_stop();

    tick(20);
    check_eq("R11 sda steady while scl high", viol, 0);
    check_eq("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule